// File: doc/BRIEF.md
# USB Line SE0 Duration Classifier

This block watches the sampled USB line state between packets and times every interval in which both data lines sit low (SE0). When the line leaves SE0, the block decides from the interval's length whether the host signalled a bus reset or a low-speed keep-alive. It raises the matching output for that one clock cycle. A short SE0, such as a one-sample glitch, produces nothing. End-of-packet handling inside packets belongs to the receiver and is not part of this block.

Thresholds come from the clock-frequency parameter `CLK_KHZ` and two duration parameters in nanoseconds. The limits are `CLK_KHZ * ns / 1_000_000` cycles, rounded down. With the defaults (48 MHz, 2500 ns, 1200 ns), the reset limit is 120 cycles and the keep-alive limit is 57 cycles. The `low_speed` input selects low-speed signalling, which is the only mode in which keep-alive is reported. The span counter saturates, so an SE0 of any length is still seen as long.

Top module: `usb_se0_classifier`

## Requirements
- R1: The line symbol encoding is 2'b00 SE0, 2'b01 J, 2'b10 K and 2'b11 SE1. While `rst_n` is low, and after it rises until an SE0 interval ends, both pulse outputs are low.
- R2: An SE0 interval's duration is the number of rising clock edges at which SE0 is sampled. The interval ends at the first sample of any other symbol (J, K or SE1).
- R3: A duration above the reset limit (120 cycles by default) raises `bus_reset_pulse`, whatever the speed. A duration of exactly 120 cycles does not.
- R4: With `low_speed` high during the exit cycle, a duration above the keep-alive limit (57 by default) and at most the reset limit raises `keep_alive_pulse`. This means 58 to 120 cycles. A duration of 57 cycles does not.
- R5: With `low_speed` low, no duration ever raises `keep_alive_pulse`.
- R6: An SE0 that lasts a single sample raises neither output.
- R7: A pulse is high for exactly the one cycle in which the non-SE0 exit symbol is present, before the clock edge that samples it. Each SE0 interval gives at most one pulse, and reset takes precedence over keep-alive.
- R8: The span counter saturates, so an SE0 of 5000 cycles still raises `bus_reset_pulse`.
- R9: If SE0 is already on the line when reset is released, the interval is timed from the first clock edge after the internal reset release. A long enough interval raises `bus_reset_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sym | input | 2 | Sampled line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| low_speed | input | 1 | High selects low-speed signalling (enables keep-alive) |
| bus_reset_pulse | output | 1 | One-cycle pulse: a long SE0 interval ended |
| keep_alive_pulse | output | 1 | One-cycle pulse: a keep-alive length SE0 ended in low-speed mode |

## Verification
Suppose the phase register wrongly stays in the SE0 phase. The next SE0 interval then adds to an old count, and a keep-alive-length SE0 shows up as a reset or as a second pulse at the exit cycle of that very interval. A counter that wraps instead of holding turns a long reset into silence, or into a keep-alive, and this shows up the moment that SE0 ends. A misplaced threshold compare shows up only when an interval ends one cycle either side of a limit, so the stimulus places interval ends on both sides of each limit.

// File: rtl/usb_se0_pkg.sv
package usb_se0_pkg;

  typedef enum logic [1:0] {
    LINE_SE0 = 2'b00,
    LINE_J   = 2'b01,
    LINE_K   = 2'b10,
    LINE_SE1 = 2'b11
  } line_sym_e;

  typedef enum logic [1:0] {
    PH_INIT = 2'd0,
    PH_IDLE = 2'd1,
    PH_SE0  = 2'd2
  } se0_phase_e;

  function automatic int span_limit(input int clk_khz, input int dur_ns);
    return (clk_khz * dur_ns) / 1000000;
  endfunction

endpackage

// File: rtl/se0_rst_sync.sv
module se0_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/se0_phase_fsm.sv
module se0_phase_fsm
  import usb_se0_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic se0_now,
  output logic span_load,
  output logic span_bump,
  output logic span_clear,
  output logic span_exit
);
  se0_phase_e phase_q;
  se0_phase_e phase_d;

  always_comb begin
    phase_d    = phase_q;
    span_load  = 1'b0;
    span_bump  = 1'b0;
    span_clear = 1'b0;
    span_exit  = 1'b0;
    unique case (phase_q)
      PH_INIT: begin
        if (se0_now) begin
          span_load = 1'b1;
          phase_d   = PH_SE0;
        end else begin
          span_clear = 1'b1;
          phase_d    = PH_IDLE;
        end
      end
      PH_IDLE: begin
        if (se0_now) begin
          span_load = 1'b1;
          phase_d   = PH_SE0;
        end
      end
      PH_SE0: begin
        if (se0_now) begin
          span_bump = 1'b1;
        end else begin
          span_exit  = 1'b1;
          span_clear = 1'b1;
          phase_d    = PH_IDLE;
        end
      end
      default: begin
        span_clear = 1'b1;
        phase_d    = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_INIT;
    else        phase_q <= phase_d;
  end

  // R2: the SE0 phase is only ever occupied after SE0 was sampled
  assert_se0_phase_follows_se0_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SE0) |-> $past(se0_now)
  );

  // R7: leaving the SE0 phase always lands in idle, never re-arms at once
  assert_exit_to_idle_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    span_exit |=> (phase_q == PH_IDLE)
  );
endmodule

// File: rtl/se0_span_counter.sv
module se0_span_counter #(
  parameter int CW  = 7,
  parameter int SAT = 121
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          span_load,
  input  logic          span_bump,
  input  logic          span_clear,
  output logic [CW-1:0] span
);
  logic [CW-1:0] span_q;
  logic [CW-1:0] span_d;
  logic          span_en;

  always_comb begin
    span_en = span_load | span_bump | span_clear;
    span_d  = span_q;
    if (span_load) begin
      span_d = CW'(1);
    end else if (span_bump) begin
      if (span_q != CW'(SAT)) span_d = span_q + 1'b1;
    end else if (span_clear) begin
      span_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       span_q <= '0;
    else if (span_en) span_q <= span_d;
  end

  assign span = span_q;

  // R8: the count never passes its ceiling
  assert_span_bounded_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    span_q <= CW'(SAT)
  );

  // R8: once at the ceiling, further SE0 samples hold it there
  assert_span_holds_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (span_bump && !span_load && span_q == CW'(SAT)) |=> (span_q == CW'(SAT))
  );
endmodule

// File: rtl/se0_span_judge.sv
module se0_span_judge #(
  parameter int CW      = 7,
  parameter int RST_LIM = 120,
  parameter int KA_LIM  = 57
) (
  input  logic [CW-1:0] span,
  input  logic          span_exit,
  input  logic          low_speed,
  output logic          reset_hit,
  output logic          keepalive_hit
);
  logic long_span;
  logic real_span;
  logic ka_span;

  generate
    if (KA_LIM < RST_LIM) begin : g_ka
      assign ka_span = low_speed && (span > CW'(KA_LIM));
    end else begin : g_no_ka
      assign ka_span = 1'b0;
    end
  endgenerate

  always_comb begin
    long_span     = span > CW'(RST_LIM);
    real_span     = span > CW'(1);
    reset_hit     = span_exit && real_span && long_span;
    keepalive_hit = span_exit && real_span && !long_span && ka_span;
  end
endmodule

// File: rtl/usb_se0_classifier.sv
module usb_se0_classifier
  import usb_se0_pkg::*;
#(
  parameter int CLK_KHZ      = 48000,
  parameter int RESET_NS     = 2500,
  parameter int KEEPALIVE_NS = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_sym,
  input  logic       low_speed,
  output logic       bus_reset_pulse,
  output logic       keep_alive_pulse
);
  localparam int RST_LIM = span_limit(CLK_KHZ, RESET_NS);
  localparam int KA_LIM  = span_limit(CLK_KHZ, KEEPALIVE_NS);
  localparam int SAT     = RST_LIM + 1;
  localparam int CW      = $clog2(SAT + 1);

  logic          rst_n_int;
  logic          se0_now;
  logic          span_load;
  logic          span_bump;
  logic          span_clear;
  logic          span_exit;
  logic [CW-1:0] span;

  assign se0_now = (line_sym == LINE_SE0);

  se0_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  se0_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .se0_now    (se0_now),
    .span_load  (span_load),
    .span_bump  (span_bump),
    .span_clear (span_clear),
    .span_exit  (span_exit)
  );

  se0_span_counter #(
    .CW  (CW),
    .SAT (SAT)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .span_load  (span_load),
    .span_bump  (span_bump),
    .span_clear (span_clear),
    .span       (span)
  );

  se0_span_judge #(
    .CW      (CW),
    .RST_LIM (RST_LIM),
    .KA_LIM  (KA_LIM)
  ) u_judge (
    .span          (span),
    .span_exit     (span_exit),
    .low_speed     (low_speed),
    .reset_hit     (bus_reset_pulse),
    .keepalive_hit (keep_alive_pulse)
  );

  // R7: a pulse never lasts into a second cycle
  assert_single_cycle_pulse_R7: assert property (
    @(posedge clk) disable iff (!rst_n_int)
    (bus_reset_pulse || keep_alive_pulse) |=> !(bus_reset_pulse || keep_alive_pulse)
  );

  // R2: pulses appear only while the line has just left SE0
  assert_pulse_on_exit_R2: assert property (
    @(posedge clk) disable iff (!rst_n_int)
    (bus_reset_pulse || keep_alive_pulse) |-> ($past(se0_now) && !se0_now)
  );

  // R6: an SE0 seen at one edge only, then gone, yields no pulse
  assert_glitch_ignored_R6: assert property (
    @(posedge clk) disable iff (!rst_n_int)
    (!$past(se0_now, 2) && $past(se0_now) && !se0_now)
      |-> !(bus_reset_pulse || keep_alive_pulse)
  );
endmodule

// File: tb/usb_se0_classifier_bench.sv
`timescale 1ns/1ps
module usb_se0_classifier_bench;
  localparam int CLK_KHZ = 48000;
  localparam int RST_LIM = (CLK_KHZ * 2500) / 1000000;  // 120
  localparam int KA_LIM  = (CLK_KHZ * 1200) / 1000000;  // 57
  localparam logic [1:0] SYM_SE0 = 2'b00;
  localparam logic [1:0] SYM_J   = 2'b01;
  localparam logic [1:0] SYM_K   = 2'b10;
  localparam logic [1:0] SYM_SE1 = 2'b11;
  localparam int KIND_NONE = 0;
  localparam int KIND_KA   = 1;
  localparam int KIND_RST  = 2;

  typedef struct {
    int    kind;
    int    cyc;
    string tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic [1:0] line_sym;
  logic       low_speed;
  logic       bus_reset_pulse;
  logic       keep_alive_pulse;

  int   cyc;
  int   n_chk;
  int   n_err;
  bit   done;
  exp_t exp_q[$];

  usb_se0_classifier #(.CLK_KHZ(CLK_KHZ)) u_usb_se0_classifier (
    .clk              (clk),
    .rst_n            (rst_n),
    .line_sym         (line_sym),
    .low_speed        (low_speed),
    .bus_reset_pulse  (bus_reset_pulse),
    .keep_alive_pulse (keep_alive_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual cyc=%0d expected completion before 150000", cyc);
      finish_run();
    end
  end

  // monitor: pop and compare as pulses appear
  always @(negedge clk) begin
    if (rst_n && (bus_reset_pulse || keep_alive_pulse)) begin
      int got;
      got = bus_reset_pulse ? (keep_alive_pulse ? 3 : KIND_RST) : KIND_KA;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R7: unexpected pulse actual kind=%0d cyc=%0d expected none", got, cyc);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (got != e.kind || cyc != e.cyc) begin
          n_err++;
          $display("FAIL %s: actual kind=%0d cyc=%0d expected kind=%0d cyc=%0d",
                   e.tag, got, cyc, e.kind, e.cyc);
        end
      end
    end
  end

  // driver: hold SE0 for len edges, then exit with sym_after
  task automatic se0_burst(input int len, input logic ls, input logic [1:0] sym_after,
                           input int kind, input string tag);
    exp_t e;
    low_speed = ls;
    line_sym  = SYM_SE0;
    repeat (len) begin
      @(posedge clk);
      #1;
    end
    if (kind != KIND_NONE) begin
      e.kind = kind;
      e.cyc  = cyc;
      e.tag  = tag;
      exp_q.push_back(e);
    end
    line_sym = sym_after;
    repeat (3) begin
      @(posedge clk);
      #1;
    end
    n_chk++;
    if (exp_q.size() != 0) begin
      n_err++;
      $display("FAIL %s: actual pending=%0d expected pulse kind=%0d after SE0 of %0d",
               tag, exp_q.size(), kind, len);
      exp_q.delete();
    end
  endtask

  initial begin
    n_chk     = 0;
    n_err     = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    line_sym  = SYM_SE0;
    low_speed = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: quiet in reset
    n_chk++;
    if (bus_reset_pulse || keep_alive_pulse) begin
      n_err++;
      $display("FAIL R1: actual rst=%0b ka=%0b expected 0 0", bus_reset_pulse, keep_alive_pulse);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R9: SE0 present at release is timed and reported
    se0_burst(150, 1'b0, SYM_J, KIND_RST, "R9");
    repeat (4) begin
      @(posedge clk);
      #1;
    end

    // R3: reset limit edges, full speed
    se0_burst(RST_LIM + 1, 1'b0, SYM_J, KIND_RST, "R3");
    se0_burst(RST_LIM, 1'b0, SYM_J, KIND_NONE, "R3");
    // R5: keep-alive lengths ignored at full speed
    se0_burst(80, 1'b0, SYM_J, KIND_NONE, "R5");
    se0_burst(KA_LIM + 1, 1'b0, SYM_K, KIND_NONE, "R5");
    // R4: keep-alive window, low speed
    se0_burst(KA_LIM + 1, 1'b1, SYM_J, KIND_KA, "R4");
    se0_burst(KA_LIM, 1'b1, SYM_J, KIND_NONE, "R4");
    se0_burst(RST_LIM, 1'b1, SYM_J, KIND_KA, "R4");
    // R7: reset wins over keep-alive; back-to-back intervals each give one pulse
    se0_burst(RST_LIM + 1, 1'b1, SYM_J, KIND_RST, "R7");
    se0_burst(60, 1'b1, SYM_K, KIND_KA, "R7");
    se0_burst(60, 1'b1, SYM_J, KIND_KA, "R7");
    // R2: exit through SE1 and through K
    se0_burst(130, 1'b1, SYM_SE1, KIND_RST, "R2");
    se0_burst(130, 1'b0, SYM_K, KIND_RST, "R2");
    // R6: single-sample SE0
    se0_burst(1, 1'b1, SYM_J, KIND_NONE, "R6");
    se0_burst(1, 1'b0, SYM_K, KIND_NONE, "R6");
    // R8: saturating counter
    se0_burst(5000, 1'b0, SYM_J, KIND_RST, "R8");
    se0_burst(5000, 1'b1, SYM_J, KIND_RST, "R8");

    done = 1'b1;
    finish_run();
  end
endmodule